// File: doc/BRIEF.md
# Group-Precomputed Adder (Select and Increment Forms)

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns the sum and the carry-out. The operand width is split into groups of a fixed size. Each group works out its result for an incoming carry of 0 and for an incoming carry of 1 before that carry is known. When the real carry reaches the group, a multiplexer picks one of the two results. The carry that leaves a group is chosen in the same way, so the long carry path passes through one select per group rather than one stage per bit.

A parameter picks one of two internal organisations:

- **Duplicated-ripple form.** Every group holds two complete ripple chains, one seeded with 0 and one seeded with 1.
- **Shared-XOR form.** The per-bit generate/propagate terms are computed once for the whole word. Each group builds only its internal prefix terms, and the carry into bit i of the group is formed as G(i-1:lo) OR (P(i-1:lo) AND group carry-in). One XOR stage, also shared by all groups, then produces the sum.

Both forms give identical results. The last group may be narrower than the rest when the width is not a multiple of the group size.

Top module: `csa_adder`

## Requirements
- R1: With the duplicated-ripple form selected, `sum_o` equals bits WIDTH-1..0 of `a_i + b_i + cin_i`.
- R2: With the duplicated-ripple form selected, `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: With the shared-XOR form selected, `{cout_o, sum_o}` equals the (WIDTH+1)-bit value `a_i + b_i + cin_i`.
- R4: When every bit position propagates (`a_i ^ b_i` all ones), `cout_o` equals `cin_i`, and `sum_o` is all ones for `cin_i`=0 and all zeros for `cin_i`=1. The carry therefore crosses every group.
- R5: A bit where both operands are 1 sends a carry into the next bit whatever `cin_i` is. This holds at a group's top bit, where the carry enters the next group. When the top operand bits are both 1, `cout_o` is 1.
- R6: When WIDTH is not a multiple of GROUP, the narrower last group still yields a correct sum and carry-out.
- R7: For identical inputs and parameters, both forms produce bit-identical `sum_o` and `cout_o`.
- R8: When every bit position kills (`a_i | b_i` all zeros), `cout_o` is 0 and `sum_o` equals `cin_i` zero-extended.
- R9: Outputs follow inputs with no clock and no stored state. A new input pattern is reflected in the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Two events can occur in the same evaluation: a group may generate its own carry-out while the carry arriving from below also has to be steered through that same group's select. If the select logic favours one of these paths, the result is wrong exactly when both are active. The bench provokes this overlap by sweeping every operand and carry combination of a 6-bit, 2-group-size instance in both forms, and by adding directed patterns: full-propagate words with a late carry-in, and generate bits placed at group boundaries. Each result is judged against wide integer addition in the bench and by comparing the two forms against each other.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

    // Internal organisation of the adder.
    typedef enum logic {
        STY_SELECT    = 1'b0,   // duplicated ripple chains per group
        STY_INCREMENT = 1'b1    // shared PG and sum XOR, prefix-carry groups
    } csa_style_e;

    // Generate / propagate pair for one bit or one bit span.
    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    // Per-bit generate and propagate.
    function automatic pg_t bit_pg(input logic a, input logic b);
        pg_t r;
        r.g = a & b;
        r.p = a ^ b;
        return r;
    endfunction

    // Combine an upper span with the span directly below it.
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Carry out of a span, given the carry entering it.
    function automatic logic pg_carry(input pg_t span, input logic cin);
        return span.g | (span.p & cin);
    endfunction

    // Three-input majority: full-adder carry.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Number of groups needed to cover w bits with groups of n bits.
    function automatic int grp_count(input int w, input int n);
        return (w + n - 1) / n;
    endfunction

    // Width of group k; the top group may be narrower.
    function automatic int grp_width(input int w, input int n, input int k);
        int lo;
        lo = k * n;
        return ((w - lo) < n) ? (w - lo) : n;
    endfunction

endpackage

// File: rtl/csa_pg_stage.sv
`timescale 1ns/1ps
// Word-wide bitwise generate/propagate, shared by all groups in the
// increment organisation.
module csa_pg_stage
    import csa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output pg_t  [WIDTH-1:0] pg_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg_o[i] = bit_pg(a_i[i], b_i[i]);
    end

endmodule

// File: rtl/csa_ripple_chain.sv
`timescale 1ns/1ps
// Plain ripple adder with a fixed carry seed; two of these make one
// group of the select organisation.
module csa_ripple_chain
    import csa_pkg::*;
#(
    parameter int GW         = 4,
    parameter bit CARRY_SEED = 1'b0
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o
);

    logic [GW:0] chain;

    always_comb begin
        chain[0] = CARRY_SEED;
        for (int i = 0; i < GW; i++) begin
            sum_o[i]    = a_i[i] ^ b_i[i] ^ chain[i];
            chain[i+1]  = maj3(a_i[i], b_i[i], chain[i]);
        end
        cout_o = chain[GW];
    end

endmodule

// File: rtl/csa_select_group.sv
`timescale 1ns/1ps
// One group of the select organisation: results for carry-in 0 and 1
// are formed in parallel and the arriving carry steers a multiplexer.
module csa_select_group
    import csa_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o
);

    logic [GW-1:0] sum_c0;
    logic [GW-1:0] sum_c1;
    logic          co_c0;
    logic          co_c1;

    csa_ripple_chain #(.GW(GW), .CARRY_SEED(1'b0)) chain0_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .sum_o  (sum_c0),
        .cout_o (co_c0)
    );

    csa_ripple_chain #(.GW(GW), .CARRY_SEED(1'b1)) chain1_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .sum_o  (sum_c1),
        .cout_o (co_c1)
    );

    // Late carry picks the precomputed result.
    assign sum_o  = cin_i ? sum_c1 : sum_c0;
    assign cout_o = cin_i ? co_c1  : co_c0;

endmodule

// File: rtl/csa_increment_group.sv
`timescale 1ns/1ps
// One group of the increment organisation. From the shared bitwise PG
// terms it forms the in-group prefix spans, then increments each prefix
// carry by the group carry-in: c(i) = G(i-1:lo) | P(i-1:lo) & cin.
module csa_increment_group
    import csa_pkg::*;
#(
    parameter int GW = 4
) (
    input  pg_t  [GW-1:0] pg_i,
    input  logic          cin_i,
    output logic [GW-1:0] carry_o,   // carry into each bit of the group
    output logic          cout_o
);

    pg_t [GW-1:0] span;   // span[i] covers bits i..lo of the group

    always_comb begin
        span[0] = pg_i[0];
        for (int i = 1; i < GW; i++) begin
            span[i] = pg_merge(pg_i[i], span[i-1]);
        end
    end

    always_comb begin
        carry_o[0] = cin_i;
        for (int i = 1; i < GW; i++) begin
            carry_o[i] = pg_carry(span[i-1], cin_i);
        end
        cout_o = pg_carry(span[GW-1], cin_i);
    end

endmodule

// File: rtl/csa_sum_xor.sv
`timescale 1ns/1ps
// Shared final sum stage: propagate XOR carry-in for every bit.
module csa_sum_xor
    import csa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  pg_t  [WIDTH-1:0] pg_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] sum_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i] = pg_i[i].p ^ carry_i[i];
    end

endmodule

// File: rtl/csa_adder.sv
`timescale 1ns/1ps
// Group-precomputed adder, top level. STYLE picks the organisation.
module csa_adder
    import csa_pkg::*;
#(
    parameter int         WIDTH = 32,
    parameter int         GROUP = 4,
    parameter csa_style_e STYLE = STY_SELECT
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NGRP = grp_count(WIDTH, GROUP);

    // grp_carry[k] enters group k; grp_carry[NGRP] leaves the word.
    logic [NGRP:0] grp_carry;

    assign grp_carry[0] = cin_i;
    assign cout_o       = grp_carry[NGRP];

    if (STYLE == STY_SELECT) begin : g_select

        for (genvar k = 0; k < NGRP; k++) begin : g_grp
            localparam int LO = k * GROUP;
            localparam int GW = grp_width(WIDTH, GROUP, k);

            csa_select_group #(.GW(GW)) grp_i (
                .a_i    (a_i[LO +: GW]),
                .b_i    (b_i[LO +: GW]),
                .cin_i  (grp_carry[k]),
                .sum_o  (sum_o[LO +: GW]),
                .cout_o (grp_carry[k+1])
            );
        end

    end else begin : g_increment

        pg_t  [WIDTH-1:0] pg_all;
        logic [WIDTH-1:0] bit_carry;

        csa_pg_stage #(.WIDTH(WIDTH)) pg_i (
            .a_i  (a_i),
            .b_i  (b_i),
            .pg_o (pg_all)
        );

        for (genvar k = 0; k < NGRP; k++) begin : g_grp
            localparam int LO = k * GROUP;
            localparam int GW = grp_width(WIDTH, GROUP, k);

            csa_increment_group #(.GW(GW)) grp_i (
                .pg_i    (pg_all[LO +: GW]),
                .cin_i   (grp_carry[k]),
                .carry_o (bit_carry[LO +: GW]),
                .cout_o  (grp_carry[k+1])
            );
        end

        csa_sum_xor #(.WIDTH(WIDTH)) xor_i (
            .pg_i    (pg_all),
            .carry_i (bit_carry),
            .sum_o   (sum_o)
        );

    end

endmodule

// File: rtl/csa_adder_chk.sv
`timescale 1ns/1ps
// Checker bound to every csa_adder instance.
module csa_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o
);

    logic [WIDTH:0] ref_total;
    logic           known;

    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        known     = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o});
    end

    always_comb begin
        if (known) begin
            // R1 / R2 / R3 / R9: outputs equal the arithmetic total with no delay
            p_sum_exact_r1: assert ({cout_o, sum_o} == ref_total)
                else $error("sum/cout differ from a+b+cin");
            p_full_prop_r4: assert (!((a_i ^ b_i) == {WIDTH{1'b1}})
                                    || (cout_o == cin_i
                                        && sum_o == {WIDTH{~cin_i}}))
                else $error("full propagate word mishandled");
            p_top_gen_r5: assert (!(a_i[WIDTH-1] && b_i[WIDTH-1]) || cout_o)
                else $error("top-bit generate lost");
            p_all_kill_r8: assert (!((a_i | b_i) == '0)
                                   || (!cout_o
                                       && sum_o == {{(WIDTH-1){1'b0}}, cin_i}))
                else $error("all-kill word mishandled");
        end
    end

endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/csa_adder_tb.sv
`timescale 1ns/1ps
module csa_adder_tb_top;
    import csa_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Three operand sets: 32/4 (main), 6/2 (exhaustive), 10/4 (uneven).
    logic [31:0] a32, b32;  logic c32;
    logic [5:0]  a6,  b6;   logic c6;
    logic [9:0]  a10, b10;  logic c10;

    logic [31:0] s32_sel, s32_inc;  logic co32_sel, co32_inc;
    logic [5:0]  s6_sel,  s6_inc;   logic co6_sel,  co6_inc;
    logic [9:0]  s10_sel, s10_inc;  logic co10_sel, co10_inc;

    csa_adder #(.WIDTH(32), .GROUP(4), .STYLE(STY_SELECT)) dut_i (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32_sel), .cout_o(co32_sel));
    csa_adder #(.WIDTH(32), .GROUP(4), .STYLE(STY_INCREMENT)) dut_inc_i (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32_inc), .cout_o(co32_inc));
    csa_adder #(.WIDTH(6), .GROUP(2), .STYLE(STY_SELECT)) small_sel_i (
        .a_i(a6), .b_i(b6), .cin_i(c6), .sum_o(s6_sel), .cout_o(co6_sel));
    csa_adder #(.WIDTH(6), .GROUP(2), .STYLE(STY_INCREMENT)) small_inc_i (
        .a_i(a6), .b_i(b6), .cin_i(c6), .sum_o(s6_inc), .cout_o(co6_inc));
    csa_adder #(.WIDTH(10), .GROUP(4), .STYLE(STY_SELECT)) odd_sel_i (
        .a_i(a10), .b_i(b10), .cin_i(c10), .sum_o(s10_sel), .cout_o(co10_sel));
    csa_adder #(.WIDTH(10), .GROUP(4), .STYLE(STY_INCREMENT)) odd_inc_i (
        .a_i(a10), .b_i(b10), .cin_i(c10), .sum_o(s10_inc), .cout_o(co10_inc));

    // Reference: (w+1)-bit total of w-bit operands.
    function automatic logic [32:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                            input logic cin, input int w);
        logic [32:0] mask;
        logic [32:0] t;
        mask = (33'd1 << w) - 33'd1;
        t = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {32'd0, cin};
        return t & ((mask << 1) | 33'd1);
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every instance with the reference and with its sibling form.
    task automatic check_all();
        logic [32:0] e32, e6, e10;
        e32 = ref_add(a32, b32, c32, 32);
        e6  = ref_add({26'd0, a6}, {26'd0, b6}, c6, 6);
        e10 = ref_add({22'd0, a10}, {22'd0, b10}, c10, 10);
        check("R1 sum sel32",  {1'b0, s32_sel}, {1'b0, e32[31:0]});
        check("R2 cout sel32", {32'd0, co32_sel}, {32'd0, e32[32]});
        check("R3 inc32",      {co32_inc, s32_inc}, e32);
        check("R7 agree32",    {co32_inc, s32_inc}, {co32_sel, s32_sel});
        check("R1 R2 sel6",    {26'd0, co6_sel, s6_sel}, e6);
        check("R3 inc6",       {26'd0, co6_inc, s6_inc}, e6);
        check("R7 agree6",     {26'd0, co6_inc, s6_inc}, {26'd0, co6_sel, s6_sel});
        check("R6 sel10",      {22'd0, co10_sel, s10_sel}, e10);
        check("R6 inc10",      {22'd0, co10_inc, s10_inc}, e10);
    endtask

    // R9: inputs change after posedge, outputs sampled at the next negedge.
    task automatic step32(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(posedge clk);
        a32 = a; b32 = b; c32 = c;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5eed));
        a32 = '0; b32 = '0; c32 = 1'b0;
        a6 = '0; b6 = '0; c6 = 1'b0;
        a10 = '0; b10 = '0; c10 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-time state: all-zero inputs give all-zero outputs (R8).
        check("R8 zero sel32", {co32_sel, s32_sel}, 33'd0);
        check("R8 zero inc32", {co32_inc, s32_inc}, 33'd0);
        rst = 1'b0;

        // R8: all-kill word, carry-in 1 -> sum 1, cout 0.
        step32(32'h0, 32'h0, 1'b1);
        check("R8 kill cin1", {co32_sel, s32_sel}, 33'd1);
        // R4: full propagate, carry crosses every group.
        step32(32'hFFFF_FFFF, 32'h0, 1'b0);
        check("R4 prop cin0", {co32_inc, s32_inc}, {1'b0, 32'hFFFF_FFFF});
        step32(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1);
        check("R4 prop cin1", {co32_sel, s32_sel}, {1'b1, 32'h0});
        // R5: generate at a group top bit enters the next group.
        step32(32'h0000_0008, 32'h0000_0008, 1'b0);
        check("R5 boundary gen", {co32_inc, s32_inc}, {1'b0, 32'h0000_0010});
        step32(32'h8000_0000, 32'h8000_0000, 1'b1);
        check("R5 top gen", {co32_sel, s32_sel}, {1'b1, 32'h0000_0001});
        step32(32'h0000_000F, 32'h0000_0001, 1'b0);
        check("R5 group carry", {co32_inc, s32_inc}, {1'b0, 32'h0000_0010});

        // R6: uneven last group corners.
        @(posedge clk);
        a10 = 10'h3FF; b10 = 10'h000; c10 = 1'b1;
        @(negedge clk);
        check("R6 odd wrap sel", {co10_sel, s10_sel}, {1'b1, 10'h000});
        check("R6 odd wrap inc", {co10_inc, s10_inc}, {1'b1, 10'h000});
        @(posedge clk);
        a10 = 10'h200; b10 = 10'h200; c10 = 1'b0;
        @(negedge clk);
        check("R6 odd top gen", {co10_inc, s10_inc}, {1'b1, 10'h000});

        // Exhaustive 6-bit sweep, random traffic on the other sets.
        for (int v = 0; v < (1 << 13); v++) begin
            @(posedge clk);
            {c6, a6, b6} = v[12:0];
            a32 = $urandom(); b32 = $urandom(); c32 = 1'(($urandom() >> 3) & 1);
            a10 = 10'($urandom()); b10 = 10'($urandom()); c10 = 1'(($urandom() >> 5) & 1);
            @(negedge clk);
            check_all();
        end

        // Random propagate-heavy words on the wide set.
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            logic [31:0] holes;
            r = $urandom();
            holes = $urandom() & $urandom() & $urandom();
            step32(r, ~r ^ holes, 1'(n & 1));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule